// File: doc/BRIEF.md
# SPI Master Controller

A polled serial-peripheral master that moves one 8-bit byte at a time in full duplex. While a byte shifts out on `mosi`, most significant bit first, a byte is shifted in from `miso`. When the eighth bit has been taken in, a one-cycle `done` pulse marks the received byte as valid. Software-side logic, or a sequencer in the same chip, writes a configuration word and then writes bytes one at a time. A write strobe that arrives while a byte is still moving is dropped and flagged as an overrun.

The configuration selects the serial clock rate, the clock polarity and phase, and the chip-select line to drive: one of three, or none. Each of the three lines has its own active level. A byte written with the hold bit set keeps its chip-select line asserted after the byte ends, so a multi-byte exchange stays framed under one continuous select. The configuration stays frozen while a byte is in flight and while a held select is open, so the framing of a burst cannot be disturbed.

Top module: `spi_master_ctl`

## Requirements
- R1: Each byte is exchanged full duplex. `rx_data` holds the 8 bits taken from `miso`, first-taken bit in bit 7. With `miso` tied to `mosi`, `rx_data` equals the byte written.
- R2: `cfg_mode[1]` is the clock idle level and `cfg_mode[0]` the phase. With phase 0, bit 7 is on `mosi` before the first clock edge, and every edge leaving the idle level samples. With phase 1, every edge returning to the idle level samples. A byte has exactly 16 clock edges, and `sclk` is at the idle level once it ends.
- R3: `cfg_cs_sel` values 0, 1 and 2 pick `cs_o` bit 0, 1 or 2. Value 3 picks no line. Only the picked line goes active, from the cycle after the write strobe through the last edge.
- R4: `cfg_cs_pol[i]`=1 makes `cs_o[i]` active high and 0 makes it active low. An inactive line sits at the complement of its active level.
- R5: One half period of `sclk` lasts 2^k system cycles, where k is `cfg_div_log2` limited to 16 (any value above 16 acts as 16). A byte lasts 16·2^k cycles from the strobe edge to `done`. With k=0, `sclk` runs at half the system clock.
- R6: After reset: k=16, mode 0, line 0 picked, all lines active low (`cs_o`=111), `sclk`=0, `busy`=0, `done`=0, `overrun`=0.
- R7: A byte written with `wr_hold`=1 leaves its select active after `done`. The select is released at the end of the first later byte written with `wr_hold`=0.
- R8: `done` is a one-cycle pulse in the cycle `busy` falls, and `rx_data` is valid in that cycle.
- R9: `wr_en` while `busy` is high starts no transfer and leaves the current byte unchanged. It raises `overrun` for one cycle, in the next cycle. This also applies in the cycle of the last clock edge.
- R10: A `cfg_we` write while `busy` is high or a held select is active has no effect on the rate, mode, line or polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_div_log2 | input | 5 | Half-period exponent k |
| cfg_mode | input | 2 | Bit 1 clock idle level, bit 0 phase |
| cfg_cs_sel | input | 2 | Chip-select pick: 0..2 line, 3 none |
| cfg_cs_pol | input | 3 | Active level per select line |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to send |
| wr_hold | input | 1 | Keep select active after this byte |
| miso | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_o | output | 3 | Chip-select lines |
| busy | output | 1 | Byte in flight |
| done | output | 1 | Byte finished pulse |
| rx_data | output | 8 | Received byte |
| overrun | output | 1 | Write dropped pulse |

## Verification
The end of a byte and a new write strobe can fall in the same cycle. At that edge `busy` is still high, so the write must be dropped and flagged instead of starting a transfer. The bench provokes this at the fastest rate by counting 15 cycles from the start strobe and driving `wr_en` just before the last clock edge. It then expects `done` and `overrun` together in the next sample, with no further byte afterwards. The bench also tries a configuration write in the gap of a held burst, which collides with the still-open select. It then checks that the following byte keeps the original line and rate.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;

  // Clock shape taken from the two-bit mode field: bit 1 idle level, bit 0 phase.
  typedef struct packed {
    logic cpol;
    logic cpha;
  } spi_mode_t;

  function automatic spi_mode_t decode_mode(input logic [1:0] m);
    spi_mode_t r;
    r.cpol = m[1];
    r.cpha = m[0];
    return r;
  endfunction

endpackage

// File: rtl/spi_edge_timer.sv
// Counts system cycles per half period of the serial clock and emits a tick
// on the last cycle of each half period while a byte is running.
module spi_edge_timer #(
  parameter int MAX_LOG2 = 16,
  parameter int SELW     = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [SELW-1:0] log2_sel,
  output logic            tick
);
  localparam int CW = (MAX_LOG2 < 1) ? 1 : MAX_LOG2;

  logic [SELW-1:0] keff;
  logic [CW:0]     span;
  logic [CW-1:0]   limit;
  logic [CW-1:0]   cnt;

  always_comb begin
    keff  = (log2_sel > SELW'(MAX_LOG2)) ? SELW'(MAX_LOG2) : log2_sel;
    span  = {{CW{1'b0}}, 1'b1} << keff;
    limit = CW'(span - 1'b1);
    tick  = run && (cnt == limit);
  end

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/spi_byte_engine.sv
// Shifts one byte out and one byte in over 2*DATA_W serial clock edges.
module spi_byte_engine #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              tick,
  input  logic              miso,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  output logic              done,
  output logic [DATA_W-1:0] rx_byte,
  output logic              byte_end
);
  localparam int EDGES = 2 * DATA_W;
  localparam int EW    = $clog2(EDGES);

  logic [EW-1:0]     edge_idx;
  logic [DATA_W-1:0] tx_sh;
  logic [DATA_W-1:0] rx_sh;
  logic              last, leading, smp, shf;

  always_comb begin
    last     = (edge_idx == EW'(EDGES - 1));
    leading  = ~edge_idx[0];
    smp      = leading ^ cpha;              // sampling edge for this phase
    shf      = ~smp && (edge_idx != '0) && !last;
    byte_end = busy && tick && last;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      sclk     <= 1'b0;
      mosi     <= 1'b0;
      done     <= 1'b0;
      rx_byte  <= '0;
      tx_sh    <= '0;
      rx_sh    <= '0;
      edge_idx <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        sclk <= cpol;
        if (start) begin
          busy     <= 1'b1;
          tx_sh    <= tx_byte;
          mosi     <= tx_byte[DATA_W-1];
          edge_idx <= '0;
        end
      end else if (tick) begin
        sclk     <= ~sclk;
        edge_idx <= edge_idx + 1'b1;
        if (smp) rx_sh <= {rx_sh[DATA_W-2:0], miso};
        if (shf) begin
          mosi  <= tx_sh[DATA_W-2];
          tx_sh <= tx_sh << 1;
        end
        if (last) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          rx_byte <= smp ? {rx_sh[DATA_W-2:0], miso} : rx_sh;
        end
      end
    end
  end

  // R2: the serial clock is back at its idle level when a byte ends
  p_sclk_home_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (sclk == cpol));

  // R8: done only in the cycle busy has just dropped
  p_done_end_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

endmodule

// File: rtl/spi_cs_driver.sv
// Holds the select-active state across bursts and drives every line at its
// own active or inactive level.
module spi_cs_driver #(
  parameter int NCS   = 3,
  parameter int PICKW = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             hold_in,
  input  logic             byte_end,
  input  logic [PICKW-1:0] pick,
  input  logic [NCS-1:0]   pol,
  output logic [NCS-1:0]   cs_o,
  output logic             held
);
  logic           hold_q;
  logic           act_nxt;
  logic [NCS-1:0] line_nxt;

  always_comb begin
    act_nxt = held;
    if (start)                   act_nxt = 1'b1;
    else if (byte_end && !hold_q) act_nxt = 1'b0;
  end

  for (genvar i = 0; i < NCS; i++) begin : g_line
    assign line_nxt[i] = (act_nxt && (pick == PICKW'(i))) ? pol[i] : ~pol[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held   <= 1'b0;
      hold_q <= 1'b0;
      cs_o   <= '1;          // reset levels are all active low
    end else begin
      held <= act_nxt;
      if (start) hold_q <= hold_in;
      cs_o <= line_nxt;
    end
  end

  // R3: at most one line sits at its active level
  p_one_line_r3: assert property (@(posedge clk) disable iff (rst)
    $stable(pol) |-> $onehot0(cs_o ^ ~pol));

  // R3: the "none" pick leaves every line inactive
  p_none_idle_r3: assert property (@(posedge clk) disable iff (rst)
    ((pick >= PICKW'(NCS)) && $stable(pick) && $stable(pol)) |-> (cs_o == ~pol));

endmodule

// File: rtl/spi_master_ctl.sv
module spi_master_ctl
  import spi_ctl_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NCS      = 3,
  parameter int MAX_LOG2 = 16,
  parameter int SELW     = 5,
  localparam int PICKW   = $clog2(NCS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [SELW-1:0]   cfg_div_log2,
  input  logic [1:0]        cfg_mode,
  input  logic [PICKW-1:0]  cfg_cs_sel,
  input  logic [NCS-1:0]    cfg_cs_pol,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_hold,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic [NCS-1:0]    cs_o,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_data,
  output logic              overrun
);
  logic [SELW-1:0]  div_q;
  spi_mode_t        mode_q;
  logic [PICKW-1:0] pick_q;
  logic [NCS-1:0]   pol_q;
  logic             held;
  logic             start;
  logic             tick;
  logic             byte_end;

  assign start = wr_en && !busy;

  // Configuration is frozen while a byte runs or a held select is open.
  always_ff @(posedge clk) begin
    if (rst) begin
      div_q   <= SELW'(MAX_LOG2);
      mode_q  <= decode_mode(2'b00);
      pick_q  <= '0;
      pol_q   <= '0;
      overrun <= 1'b0;
    end else begin
      if (cfg_we && !busy && !held) begin
        div_q  <= cfg_div_log2;
        mode_q <= decode_mode(cfg_mode);
        pick_q <= cfg_cs_sel;
        pol_q  <= cfg_cs_pol;
      end
      overrun <= wr_en && busy;
    end
  end

  spi_edge_timer #(.MAX_LOG2(MAX_LOG2), .SELW(SELW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .run      (busy),
    .log2_sel (div_q),
    .tick     (tick)
  );

  spi_byte_engine #(.DATA_W(DATA_W)) u_engine (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .tx_byte  (wr_data),
    .cpol     (mode_q.cpol),
    .cpha     (mode_q.cpha),
    .tick     (tick),
    .miso     (miso),
    .busy     (busy),
    .sclk     (sclk),
    .mosi     (mosi),
    .done     (done),
    .rx_byte  (rx_data),
    .byte_end (byte_end)
  );

  spi_cs_driver #(.NCS(NCS), .PICKW(PICKW)) u_cs (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .hold_in  (wr_hold),
    .byte_end (byte_end),
    .pick     (pick_q),
    .pol      (pol_q),
    .cs_o     (cs_o),
    .held     (held)
  );

  // R9: an overrun only follows a cycle in which a byte was in flight
  p_overrun_busy_r9: assert property (@(posedge clk) disable iff (rst)
    overrun |-> $past(busy));

  // R10: configuration holds while a byte or a held select is open
  p_cfg_lock_r10: assert property (@(posedge clk) disable iff (rst)
    (busy || held) |=> ($stable(div_q) && $stable(mode_q) &&
                        $stable(pick_q) && $stable(pol_q)));

endmodule

// File: tb/spi_master_ctl_bench.sv
module spi_master_ctl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG       = 190000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [4:0] cfg_div_log2 = '0;
  logic [1:0] cfg_mode = '0;
  logic [1:0] cfg_cs_sel = '0;
  logic [2:0] cfg_cs_pol = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       wr_hold = 1'b0;
  logic       miso;
  logic       miso_force = 1'b0;
  logic       miso_val = 1'b0;
  logic       sclk, mosi, busy, done, overrun;
  logic [2:0] cs_o;
  logic [7:0] rx_data;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign miso = miso_force ? miso_val : mosi;

  spi_master_ctl u_spi_master_ctl (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_div_log2(cfg_div_log2),
    .cfg_mode(cfg_mode), .cfg_cs_sel(cfg_cs_sel), .cfg_cs_pol(cfg_cs_pol),
    .wr_en(wr_en), .wr_data(wr_data), .wr_hold(wr_hold), .miso(miso),
    .sclk(sclk), .mosi(mosi), .cs_o(cs_o), .busy(busy), .done(done),
    .rx_data(rx_data), .overrun(overrun)
  );

  int n_chk = 0, n_bad = 0;
  int cyc = 0, start_cyc = 0, first_cyc = 0, n_edges = 0;
  bit finished = 0, cs_bad = 0;
  logic [7:0] cap = '0;
  logic prev_sclk = 1'b0;
  int b_k = 16;
  logic [1:0] b_mode = 2'b00, b_sel = 2'b00;
  logic [2:0] b_pol = 3'b000;
  logic [7:0] q_rx[$], q_tx[$];
  bit q_hold[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_cs(input bit act);
    logic [2:0] r;
    for (int i = 0; i < 3; i++)
      r[i] = (act && b_sel == 2'(i)) ? b_pol[i] : ~b_pol[i];
    return r;
  endfunction

  // start detection at the edge that accepts the strobe
  always @(posedge clk) begin
    cyc++;
    if (!rst && wr_en && !busy) begin
      start_cyc = cyc;
      n_edges   = 0;
      cap       = '0;
      cs_bad    = 0;
    end
  end

  // monitor: watches the serial pins and pops the scoreboard on each done
  always @(negedge clk) begin
    if (!rst) begin
      if (sclk !== prev_sclk && (busy || done)) begin
        n_edges++;
        if (n_edges == 1) first_cyc = cyc;
        if ((sclk !== b_mode[1]) != b_mode[0]) cap = {cap[6:0], mosi};
        if (busy && cs_o !== exp_cs(1'b1)) cs_bad = 1;
      end
      if (done) begin
        if (q_rx.size() == 0) chk(0, "R9", "unexpected done", rx_data, 0);
        else begin
          logic [7:0] er, et;
          bit eh;
          er = q_rx.pop_front();
          et = q_tx.pop_front();
          eh = q_hold.pop_front();
          chk(rx_data == er, "R1", "received byte", rx_data, er);
          chk(cap == et, "R2", "mosi at sample edges", cap, et);
          chk(n_edges == 16, "R2", "sclk edges per byte", n_edges, 16);
          chk(cyc - start_cyc == (16 << b_k), "R5", "byte duration",
              cyc - start_cyc, 16 << b_k);
          chk(sclk == b_mode[1], "R2", "sclk idle after byte", sclk, b_mode[1]);
          chk(!cs_bad, "R3", "select pattern during byte", cs_bad, 0);
          chk(cs_o == exp_cs(eh), "R7", "select after byte", cs_o, exp_cs(eh));
          chk(!busy, "R8", "busy low with done", busy, 0);
        end
      end
    end
    prev_sclk = sclk;
  end

  task automatic do_cfg(input int k, input logic [1:0] m, input logic [1:0] s,
                        input logic [2:0] p, input bit take);
    @(negedge clk);
    cfg_div_log2 = 5'(k); cfg_mode = m; cfg_cs_sel = s; cfg_cs_pol = p;
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    if (take) begin
      b_k = (k > 16) ? 16 : k; b_mode = m; b_sel = s; b_pol = p;
    end
  endtask

  task automatic send(input logic [7:0] d, input bit hold, input bit push,
                      input logic [7:0] exp_rx);
    @(negedge clk);
    while (busy) @(negedge clk);
    if (push) begin
      q_rx.push_back(exp_rx); q_tx.push_back(d); q_hold.push_back(hold);
    end
    wr_data = d; wr_hold = hold; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  task automatic pulse_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    b_k = 16; b_mode = 2'b00; b_sel = 2'b00; b_pol = 3'b000;
  endtask

  // default rate: first edge one half period of 65536 cycles after the strobe
  task automatic first_edge_check(input string req);
    send(8'h5A, 0, 0, 8'h00);
    while (n_edges < 1) @(negedge clk);
    chk(first_cyc - start_cyc == 65536, req, "first half period",
        first_cyc - start_cyc, 65536);
    chk(sclk == 1'b1, req, "mode 0 first edge level", sclk, 1);
    chk(cs_o == 3'b110, req, "line 0 active low", cs_o, 3'b110);
    pulse_reset();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R6 reset state
    chk(cs_o == 3'b111, "R6", "cs after reset", cs_o, 3'b111);
    chk(sclk == 1'b0, "R6", "sclk after reset", sclk, 0);
    chk(!busy && !done && !overrun, "R6", "status after reset",
        {busy, done, overrun}, 0);
    first_edge_check("R6");

    // R1 R2 R3 R4 R5: modes, lines and polarities at several rates
    do_cfg(0, 2'd0, 2'd0, 3'b000, 1); send(8'hA5, 0, 1, 8'hA5); wait_done();
    do_cfg(1, 2'd1, 2'd1, 3'b010, 1); send(8'h3C, 0, 1, 8'h3C); wait_done();
    do_cfg(2, 2'd2, 2'd2, 3'b100, 1); send(8'hC3, 0, 1, 8'hC3); wait_done();
    do_cfg(3, 2'd3, 2'd0, 3'b101, 1); send(8'h17, 0, 1, 8'h17); wait_done();
    // R3: "none" keeps every line inactive
    do_cfg(0, 2'd3, 2'd3, 3'b011, 1); send(8'h81, 0, 1, 8'h81); wait_done();
    chk(cs_o == 3'b100, "R3", "none pick idle levels", cs_o, 3'b100);

    // R1: receive path independent of the sent byte
    do_cfg(1, 2'd0, 2'd1, 3'b000, 1);
    miso_force = 1'b1; miso_val = 1'b1;
    send(8'h00, 0, 1, 8'hFF); wait_done();
    miso_val = 1'b0;
    send(8'hFF, 0, 1, 8'h00); wait_done();
    miso_force = 1'b0;

    // R7 R10: held burst, config write in the gap is ignored
    send(8'h11, 1, 1, 8'h11); wait_done();
    do_cfg(0, 2'd2, 2'd2, 3'b111, 0);
    repeat (3) @(negedge clk);
    chk(cs_o == 3'b101, "R7", "select held in gap", cs_o, 3'b101);
    send(8'h22, 1, 1, 8'h22); wait_done();
    send(8'h33, 0, 1, 8'h33); wait_done();
    chk(cs_o == 3'b111, "R7", "select released after burst", cs_o, 3'b111);

    // R9 R10: write and config strobes while busy
    do_cfg(2, 2'd1, 2'd0, 3'b000, 1);
    send(8'h96, 0, 1, 8'h96);
    repeat (4) @(negedge clk);
    wr_data = 8'h00; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    chk(overrun == 1'b1, "R9", "overrun pulse", overrun, 1);
    do_cfg(5, 2'd2, 2'd1, 3'b111, 0);
    wait_done();
    send(8'h4B, 0, 1, 8'h4B); wait_done();

    // R9 R8: write strobe lands on the last clock edge
    do_cfg(0, 2'd0, 2'd0, 3'b000, 1);
    send(8'h69, 0, 1, 8'h69);
    while (cyc - start_cyc != 15) @(negedge clk);
    wr_data = 8'hFF; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    chk(overrun == 1'b1, "R9", "overrun on last edge", overrun, 1);
    chk(done == 1'b1, "R8", "done with colliding write", done, 1);
    repeat (30) @(negedge clk);
    chk(!busy, "R9", "no transfer from dropped write", busy, 0);

    // R5: exponents above 16 act as 16
    do_cfg(31, 2'd0, 2'd0, 3'b000, 1);
    first_edge_check("R5");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule